// File: doc/BRIEF.md
# Vectorised Condition-Field Predicate Packer

This block runs a masked reduction over a vector of 4-bit condition fields and turns the per-element results into integer predicate bits. Each element reads one field. In vector-source mode the fields are consecutive, starting at a base field number. In scalar-source mode every element reuses the base field. Each element compares every field bit with a per-bit polarity, gates the comparisons with a per-bit enable, and folds the four terms into one bit with either OR or AND.

The element results go to the integer side in one of two ways. In scalar-destination mode the block stays on one destination register and places element i at bit i, counting up from the least significant bit. It issues a single bit-masked write once all elements are done. In vector-destination mode each element goes to bit 0 of its own register, and the register number advances per element. An element-width setting limits the writes to the low 8, 16, 32 or 64 bits of a register. The condition fields are not affected by that setting.

A one-cycle start pulse launches a run, and a one-cycle done pulse ends it. The field read port is combinational: the block drives an address and samples the returned field in the same cycle. The integer write port carries a per-bit write mask.

Top module: `cond_pack_seq`

## Requirements
- R1: For field bits f[3:0] (bit k on `fld_data[k]`), term k is `en_mask[k] & (polarity[k] == f[k])`. The element result is the OR of the four terms when `or_fold`=1 and their AND when `or_fold`=0.
- R2: When `src_vec`=1, element i reads field `(fld_base + i) mod 64`. When `src_vec`=0, every element reads field `fld_base`.
- R3: When `dst_vec`=0, element i's result lands in bit i of register `dst_reg`. This is done by exactly one write after the last element.
- R4: In scalar-destination mode the bits from the effective VL up to the element width are written as 0. Bits at and above the element width keep their old value, because `wr_mask` excludes them.
- R5: When `dst_vec`=1, element i writes register `(dst_reg + i) mod 32`. The write has the result in bit 0, zeros in bits 1 to width-1, and leaves all bits at and above the element width unchanged.
- R6: `ewidth` codes 0, 1, 2 and 3 select widths of 8, 16, 32 and 64 bits. In scalar-destination mode a VL larger than the width is clamped to the width. In vector-destination mode VL is clamped to 64.
- R7: The block handles one element per clock. After the clock edge that accepts `start`, `done` rises after VL+1 edges in vector-destination mode and after VL+2 edges in scalar-destination mode, where VL is the effective VL. `done` lasts one cycle, and `busy` is high from acceptance until `done` falls.
- R8: `start` is ignored while `busy` is high. An ignored start makes no write and does not change the timing of the run in progress.
- R9: VL=0 makes no write in vector-destination mode. In scalar-destination mode it writes zeros into the low element-width bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch pulse, accepted when idle |
| vl | input | 7 | Requested vector length |
| fld_base | input | 6 | Base condition field number |
| src_vec | input | 1 | 1: fields advance per element |
| dst_reg | input | 5 | Base destination register number |
| dst_vec | input | 1 | 1: one register per element |
| en_mask | input | 4 | Per-bit term enable |
| polarity | input | 4 | Per-bit value to compare with |
| or_fold | input | 1 | 1: OR fold, 0: AND fold |
| ewidth | input | 2 | Destination element width code |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| fld_addr | output | 6 | Field read address |
| fld_data | input | 4 | Field read data, same cycle |
| wr_en | output | 1 | Integer write strobe |
| wr_addr | output | 5 | Integer write register |
| wr_data | output | 64 | Integer write data |
| wr_mask | output | 64 | Per-bit write enable |

## Verification
The bench builds the block with its default parameters: 64 fields, 64-bit registers and 32 registers. With these values the widest element width can be clamped against, and both address wraps can be reached: fields 60 to 63 roll over to 0, and registers 28 to 31 roll over to 0. A bench model of the register file applies the masked writes, so bits above the element width, untouched registers, VL=0 and ignored starts can all be checked at the write port.

// File: rtl/cpk_pkg.sv
package cpk_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_FLUSH = 2'd2,
    ST_DONE  = 2'd3
  } cpk_state_e;

  // element width in bits for a width code
  function automatic int ew_bits(input logic [1:0] code);
    return 8 << code;
  endfunction
endpackage

// File: rtl/cpk_reduce.sv
module cpk_reduce #(
  parameter int FB = 4
) (
  input  logic [FB-1:0] fld,
  input  logic [FB-1:0] en_mask,
  input  logic [FB-1:0] polarity,
  input  logic          or_fold,
  output logic          res
);
  logic [FB-1:0] term;

  for (genvar k = 0; k < FB; k++) begin : g_term
    assign term[k] = en_mask[k] & (polarity[k] == fld[k]);
  end

  assign res = or_fold ? |term : &term;
endmodule

// File: rtl/cpk_ctrl.sv
module cpk_ctrl
  import cpk_pkg::*;
#(
  parameter int VLW = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [VLW-1:0] vl_new,
  input  logic           scal_new,
  input  logic [VLW-1:0] vl_q,
  input  logic           scal_q,
  output cpk_state_e     state,
  output logic [VLW-1:0] idx,
  output logic           accept
);
  cpk_state_e     state_d;
  logic [VLW-1:0] idx_d;

  assign accept = (state == ST_IDLE) && start;

  always_comb begin
    state_d = state;
    idx_d   = idx;
    unique case (state)
      ST_IDLE: if (start) begin
        idx_d = '0;
        if (vl_new == '0) state_d = scal_new ? ST_FLUSH : ST_DONE;
        else              state_d = ST_RUN;
      end
      ST_RUN: begin
        idx_d = idx + 1'b1;
        if (idx == vl_q - 1'b1) state_d = scal_q ? ST_FLUSH : ST_DONE;
      end
      ST_FLUSH: state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      idx   <= '0;
    end else begin
      state <= state_d;
      idx   <= idx_d;
    end
  end

  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN) |-> (idx < vl_q)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DONE) |=> (state == ST_IDLE)); // R7
endmodule

// File: rtl/cpk_accum.sv
module cpk_accum #(
  parameter int XLEN = 64,
  parameter int VLW  = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            en,
  input  logic [VLW-1:0]  idx,
  input  logic            bit_in,
  output logic [XLEN-1:0] packed_q
);
  localparam int IXW = $clog2(XLEN);
  logic [XLEN-1:0] packed_d;

  always_comb begin
    packed_d = packed_q;
    if (clr)     packed_d = '0;
    else if (en) packed_d[idx[IXW-1:0]] = bit_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         packed_q <= '0;
    else if (clr || en) packed_q <= packed_d;
  end
endmodule

// File: rtl/cond_pack_seq.sv
module cond_pack_seq
  import cpk_pkg::*;
#(
  parameter int NFIELD = 64,
  parameter int XLEN   = 64,
  parameter int NREG   = 32,
  localparam int FAW   = $clog2(NFIELD),
  localparam int RAW   = $clog2(NREG),
  localparam int VLW   = $clog2((NFIELD > XLEN) ? NFIELD : XLEN) + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [VLW-1:0]  vl,
  input  logic [FAW-1:0]  fld_base,
  input  logic            src_vec,
  input  logic [RAW-1:0]  dst_reg,
  input  logic            dst_vec,
  input  logic [3:0]      en_mask,
  input  logic [3:0]      polarity,
  input  logic            or_fold,
  input  logic [1:0]      ewidth,
  output logic            busy,
  output logic            done,
  output logic [FAW-1:0]  fld_addr,
  input  logic [3:0]      fld_data,
  output logic            wr_en,
  output logic [RAW-1:0]  wr_addr,
  output logic [XLEN-1:0] wr_data,
  output logic [XLEN-1:0] wr_mask
);
  cpk_state_e      state;
  logic [VLW-1:0]  idx, vl_lim, vl_eff, vl_q;
  logic            accept, elem_res;
  logic [XLEN-1:0] ewm_new, ewm_q, packed_q;
  logic [FAW-1:0]  base_q;
  logic [RAW-1:0]  dst_q;
  logic            src_vec_q, dst_vec_q, or_fold_q;
  logic [3:0]      en_mask_q, polarity_q;

  // effective VL and element-width mask from the launch inputs
  always_comb begin
    vl_lim  = dst_vec ? VLW'(NFIELD) : VLW'(ew_bits(ewidth));
    vl_eff  = (vl > vl_lim) ? vl_lim : vl;
    ewm_new = {XLEN{1'b1}} >> (XLEN - ew_bits(ewidth));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vl_q <= '0; ewm_q <= '0; base_q <= '0; dst_q <= '0;
      src_vec_q <= 1'b0; dst_vec_q <= 1'b0; or_fold_q <= 1'b0;
      en_mask_q <= '0; polarity_q <= '0;
    end else if (accept) begin
      vl_q <= vl_eff; ewm_q <= ewm_new; base_q <= fld_base; dst_q <= dst_reg;
      src_vec_q <= src_vec; dst_vec_q <= dst_vec; or_fold_q <= or_fold;
      en_mask_q <= en_mask; polarity_q <= polarity;
    end
  end

  cpk_ctrl #(.VLW(VLW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .vl_new(vl_eff), .scal_new(!dst_vec),
    .vl_q(vl_q), .scal_q(!dst_vec_q),
    .state(state), .idx(idx), .accept(accept)
  );

  cpk_reduce #(.FB(4)) u_reduce (
    .fld(fld_data), .en_mask(en_mask_q), .polarity(polarity_q),
    .or_fold(or_fold_q), .res(elem_res)
  );

  cpk_accum #(.XLEN(XLEN), .VLW(VLW)) u_accum (
    .clk(clk), .rst_n(rst_n), .clr(accept),
    .en((state == ST_RUN) && !dst_vec_q),
    .idx(idx), .bit_in(elem_res), .packed_q(packed_q)
  );

  assign fld_addr = src_vec_q ? (base_q + idx[FAW-1:0]) : base_q;
  assign busy     = (state != ST_IDLE);
  assign done     = (state == ST_DONE);
  assign wr_en    = ((state == ST_RUN) && dst_vec_q) || (state == ST_FLUSH);
  assign wr_addr  = (state == ST_FLUSH) ? dst_q : (dst_q + idx[RAW-1:0]);
  assign wr_data  = (state == ST_FLUSH) ? (packed_q & ewm_q)
                                        : {{(XLEN-1){1'b0}}, elem_res};
  assign wr_mask  = ewm_q;

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && $past(state) == ST_RUN && src_vec_q)
      |-> (fld_addr == $past(fld_addr) + 1'b1)); // R2
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && $past(state) == ST_RUN && !src_vec_q)
      |-> $stable(fld_addr)); // R2
  AST_VEC_LSB_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && state == ST_RUN) |-> (wr_data[XLEN-1:1] == '0)); // R5
  AST_CLEAR_ABOVE_VL: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FLUSH) |-> ((wr_data >> vl_q) == '0)); // R4
  AST_DATA_IN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ((wr_data & ~wr_mask) == '0)); // R4
  AST_ONE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FLUSH) |=> !wr_en); // R3
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && state == ST_RUN && dst_vec_q) |=> $stable(dst_q)); // R8
endmodule

// File: tb/cond_pack_seq_test.sv
module cond_pack_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [6:0]  vl = '0;
  logic [5:0]  fld_base = '0;
  logic        src_vec = 1'b0;
  logic [4:0]  dst_reg = '0;
  logic        dst_vec = 1'b0;
  logic [3:0]  en_mask = '0, polarity = '0;
  logic        or_fold = 1'b0;
  logic [1:0]  ewidth = '0;
  logic        busy, done, wr_en;
  logic [5:0]  fld_addr;
  logic [3:0]  fld_data;
  logic [4:0]  wr_addr;
  logic [63:0] wr_data, wr_mask;

  logic [3:0]  fmem [64];
  logic [63:0] rf [32];
  logic        pl_en = 1'b0;
  logic [4:0]  pl_addr = '0;
  logic [63:0] pl_data = '0;
  int nchk = 0, nfail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  cond_pack_seq uut (
    .clk(clk), .rst_n(rst_n), .start(start), .vl(vl), .fld_base(fld_base),
    .src_vec(src_vec), .dst_reg(dst_reg), .dst_vec(dst_vec),
    .en_mask(en_mask), .polarity(polarity), .or_fold(or_fold), .ewidth(ewidth),
    .busy(busy), .done(done), .fld_addr(fld_addr), .fld_data(fld_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_mask(wr_mask)
  );

  assign fld_data = fmem[fld_addr];

  always @(posedge clk) begin
    if (wr_en)      rf[wr_addr] <= (rf[wr_addr] & ~wr_mask) | (wr_data & wr_mask);
    else if (pl_en) rf[pl_addr] <= pl_data;
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic red(input logic [3:0] f, input logic [3:0] m,
                               input logic [3:0] p, input logic o);
    logic [3:0] t;
    for (int k = 0; k < 4; k++) t[k] = m[k] & (p[k] == f[k]);
    return o ? |t : &t;
  endfunction

  task automatic preload(input int a, input logic [63:0] d);
    @(negedge clk); pl_en = 1'b1; pl_addr = 5'(a); pl_data = d;
    @(negedge clk); pl_en = 1'b0;
  endtask

  // runs one operation, checks cycle count and every register
  task automatic run_case(input string tag, input int nvl, input int base, input bit sv,
                          input int dst, input bit dv, input logic [3:0] mk,
                          input logic [3:0] pv, input bit of, input int ew);
    logic [63:0] exp [32];
    logic [63:0] ewm, val;
    int ewb, lim, vle, cyc;
    for (int a = 0; a < 32; a++) exp[a] = rf[a];
    ewb = 8 << ew;
    ewm = (ewb == 64) ? '1 : ((64'd1 << ewb) - 1);
    lim = dv ? 64 : ewb;
    vle = (nvl > lim) ? lim : nvl;
    if (dv) begin
      for (int i = 0; i < vle; i++) begin
        int a = (dst + i) % 32;
        exp[a] = (exp[a] & ~ewm) | 64'(red(fmem[sv ? (base + i) % 64 : base], mk, pv, of));
      end
    end else begin
      val = '0;
      for (int i = 0; i < vle; i++) val[i] = red(fmem[sv ? (base + i) % 64 : base], mk, pv, of);
      exp[dst] = (exp[dst] & ~ewm) | (val & ewm);
    end
    @(negedge clk);
    vl = 7'(nvl); fld_base = 6'(base); src_vec = sv; dst_reg = 5'(dst); dst_vec = dv;
    en_mask = mk; polarity = pv; or_fold = of; ewidth = 2'(ew); start = 1'b1;
    @(posedge clk); @(negedge clk); start = 1'b0; cyc = 1;
    while (!done && cyc < 200) begin @(posedge clk); @(negedge clk); cyc++; end
    check({tag, " R7 cycles"}, 64'(cyc), 64'(vle + (dv ? 1 : 2)));
    @(posedge clk); @(negedge clk);
    check({tag, " R7 done one cycle"}, {63'd0, done}, 64'd0);
    for (int a = 0; a < 32; a++) check({tag, " reg"}, rf[a], exp[a]);
  endtask

  task automatic t_reset;
    check("R7 reset busy", {63'd0, busy}, 64'd0);
    check("R7 reset done", {63'd0, done}, 64'd0);
    check("R3 reset wr_en", {63'd0, wr_en}, 64'd0);
  endtask

  task automatic t_scalar_pack;
    preload(3, '1);
    run_case("R1 R2 R3 R4 scalar vec-src or", 20, 5, 1'b1, 3, 1'b0, 4'b1011, 4'b0110, 1'b1, 3);
    preload(4, 64'h0123_4567_89ab_cdef);
    run_case("R1 R2 R3 scalar vec-src and", 16, 40, 1'b1, 4, 1'b0, 4'b0011, 4'b0001, 1'b0, 1);
    run_case("R1 R2 R3 scalar scalar-src", 5, 9, 1'b0, 5, 1'b0, 4'b1111, 4'b1010, 1'b1, 0);
  endtask

  task automatic t_clamp;
    preload(7, '1);
    run_case("R4 R6 ew8 clamp", 30, 0, 1'b1, 7, 1'b0, 4'b1100, 4'b0100, 1'b0, 0);
    preload(8, '1);
    run_case("R6 ew32 clamp", 50, 17, 1'b1, 8, 1'b0, 4'b0001, 4'b0000, 1'b1, 2);
    run_case("R6 vector clamp 64", 100, 3, 1'b1, 1, 1'b1, 4'b0110, 4'b0010, 1'b1, 3);
  endtask

  task automatic t_vector;
    for (int a = 0; a < 32; a++) preload(a, '1);
    run_case("R2 R5 vector wrap regs", 6, 9, 1'b0, 28, 1'b1, 4'b1111, 4'b1111, 1'b0, 1);
    run_case("R1 R2 R5 vector wrap fields", 10, 60, 1'b1, 12, 1'b1, 4'b1010, 4'b1000, 1'b1, 3);
    run_case("R5 vector ew8", 4, 20, 1'b1, 2, 1'b1, 4'b0101, 4'b0100, 1'b1, 0);
  endtask

  task automatic t_vl_zero;
    preload(11, '1);
    run_case("R9 scalar vl0", 0, 0, 1'b1, 11, 1'b0, 4'b1111, 4'b0000, 1'b1, 2);
    preload(12, 64'h5555_aaaa_5555_aaaa);
    run_case("R9 vector vl0", 0, 0, 1'b1, 12, 1'b1, 4'b1111, 4'b0000, 1'b1, 3);
  endtask

  task automatic t_busy_ignore;
    int cyc;
    preload(20, 64'hdead_beef_cafe_f00d);
    preload(0, '0);
    @(negedge clk);
    vl = 7'd5; fld_base = 6'd0; src_vec = 1'b1; dst_reg = 5'd0; dst_vec = 1'b1;
    en_mask = 4'b1111; polarity = 4'b0000; or_fold = 1'b1; ewidth = 2'd3; start = 1'b1;
    @(posedge clk); @(negedge clk);
    vl = 7'd3; dst_reg = 5'd20; dst_vec = 1'b0; cyc = 1;
    @(posedge clk); @(negedge clk); start = 1'b0; cyc++;
    while (!done && cyc < 200) begin @(posedge clk); @(negedge clk); cyc++; end
    check("R8 timing unchanged", 64'(cyc), 64'd6);
    repeat (3) @(negedge clk);
    check("R8 ignored start no write", rf[20], 64'hdead_beef_cafe_f00d);
    check("R8 run result reg0", rf[0], 64'(red(fmem[0], 4'b1111, 4'b0000, 1'b1)));
    check("R8 idle after run", {63'd0, busy}, 64'd0);
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    if (!finished) begin
      nfail++; nchk++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) fmem[i] = 4'((i * 7 + 3) ^ (i >> 2));
    for (int a = 0; a < 32; a++) rf[a] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_scalar_pack();
    t_clamp();
    t_vector();
    t_vl_zero();
    t_busy_ignore();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule